// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit walks a multi-register memory transfer one word at a time. A transfer is launched by a one-cycle start pulse. The start pulse carries a 16-bit register mask, a base address, a 2-bit addressing mode and a writeback enable. For every set bit in the mask, starting with the lowest, the sequencer presents one beat: the register number and the word address. It holds each beat until the memory side accepts it through a valid/ready handshake.

Before the first beat, the sequencer counts the set bits in the mask. From that count it derives the first address, so the memory side always sees addresses that step upward by one word, whatever the mode. When the last beat is accepted, a one-cycle done pulse appears. The updated base value is shown alongside it, flagged valid only if writeback was requested. Moving the data and updating the register file belong to the surrounding logic.

Top module: `blk_addr_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `beatValid`, `done` and `wbValid` are all low.
- R2: Mode 0 (bit 1 clear = ascending, bit 0 clear = after): the first beat address equals the base.
- R3: Mode 1 (ascending, before): the first beat address equals base + 4.
- R4: Mode 2 (descending, after): the first beat address equals base − 4·n + 4, where n is the number of set mask bits.
- R5: Mode 3 (descending, before): the first beat address equals base − 4·n.
- R6: Beats come in strictly ascending register order, one per set mask bit. Each accepted beat is followed by an address 4 higher, computed modulo 2^32.
- R7: While `beatValid` is high and `beatReady` is low, the beat index and address stay unchanged on the next cycle.
- R8: `done` is high for exactly one cycle, starting the cycle after the last beat is accepted. `wbValid` is high only in that cycle, and only if writeback was enabled at start.
- R9: During `done`, `wbAddr` is base + 4·n for modes 0 and 1, and base − 4·n for modes 2 and 3.
- R10: An empty mask produces no beats. In that case `done` rises in the cycle after start is sampled, and `wbAddr` equals the base.
- R11: `start` is ignored whenever `busy` is high, including the `done` cycle. Parameters sampled at launch govern the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| regList | input | 16 | Register mask, bit i selects register i |
| baseAddr | input | 32 | Base address |
| addrMode | input | 2 | Bit 1: descending; bit 0: adjust before |
| wbEn | input | 1 | Request a writeback value |
| beatReady | input | 1 | Memory side accepts the current beat |
| beatValid | output | 1 | A beat is presented |
| beatIdx | output | 4 | Register number of the current beat |
| beatAddr | output | 32 | Word address of the current beat |
| busy | output | 1 | Transfer in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Writeback value is to be applied |
| wbAddr | output | 32 | Updated base value, meaningful with done |

## Verification
Two things can collide in one cycle: a fresh launch request arriving while a transfer is still running, and the transfer itself finishing. To provoke this, the bench holds `start` high with different parameters for the whole transfer, under a stalling ready pattern, and keeps it high through the acceptance of the final beat and the `done` cycle. The scoreboard expects only the beats and the writeback of the first launch. One cycle after `done`, the bench requires the block to be idle with no beat presented. Any accepted relaunch would show up as extra or misaddressed beats, or as a block that is still busy.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture launch parameters
    logic advance;  // current beat accepted
  } seqStrobe_t;

endpackage

// File: rtl/blkseq_dp.sv
module blkseq_dp
  import blkseq_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  seqStrobe_t              strobe,
  input  logic [NREG-1:0]         regList,
  input  logic [ADDR_W-1:0]       baseAddr,
  input  logic [1:0]              addrMode,
  input  logic                    wbEn,
  output logic                    inListEmpty,
  output logic                    lastBeat,
  output logic [$clog2(NREG)-1:0] beatIdx,
  output logic [ADDR_W-1:0]       beatAddr,
  output logic [ADDR_W-1:0]       wbAddr,
  output logic                    wbFlag
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam int SH    = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [NREG-1:0]   remList;
  logic [NREG-1:0]   lowBit;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] wbReg;
  logic [CNT_W-1:0]  setCount;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] wbNext;

  // population count of the incoming mask
  always_comb begin
    setCount = '0;
    for (int i = 0; i < NREG; i++) setCount = setCount + CNT_W'(regList[i]);
  end

  assign span = ADDR_W'(setCount) << SH;

  // first address so that beats always ascend
  always_comb begin
    unique case (addrMode)
      2'd0:    startAddr = baseAddr;
      2'd1:    startAddr = baseAddr + STEP;
      2'd2:    startAddr = baseAddr - span + STEP;
      default: startAddr = baseAddr - span;
    endcase
  end

  assign wbNext      = addrMode[1] ? (baseAddr - span) : (baseAddr + span);
  assign inListEmpty = (regList == '0);

  // lowest pending register
  assign lowBit   = remList & (~remList + NREG'(1));
  assign lastBeat = ((remList & (remList - NREG'(1))) == '0);

  always_comb begin
    beatIdx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (remList[i]) beatIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remList <= '0;
      curAddr <= '0;
      wbReg   <= '0;
      wbFlag  <= 1'b0;
    end else if (strobe.load) begin
      remList <= regList;
      curAddr <= startAddr;
      wbReg   <= wbNext;
      wbFlag  <= wbEn;
    end else if (strobe.advance) begin
      remList <= remList & ~lowBit;
      curAddr <= curAddr + STEP;
    end
  end

  assign beatAddr = curAddr;
  assign wbAddr   = wbReg;

endmodule

// File: rtl/blkseq_ctrl.sv
module blkseq_ctrl
  import blkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       beatReady,
  input  logic       inListEmpty,
  input  logic       lastBeat,
  output seqStrobe_t strobe,
  output logic       beatValid,
  output logic       busy,
  output logic       done
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = inListEmpty ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (beatReady) begin
          strobe.advance = 1'b1;
          if (lastBeat) stateNext = ST_FIN;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign beatValid = (state == ST_RUN);
  assign done      = (state == ST_FIN);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/blk_addr_seq.sv
module blk_addr_seq
  import blkseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] regList,
  input  logic [31:0] baseAddr,
  input  logic [1:0]  addrMode,
  input  logic        wbEn,
  input  logic        beatReady,
  output logic        beatValid,
  output logic [3:0]  beatIdx,
  output logic [31:0] beatAddr,
  output logic        busy,
  output logic        done,
  output logic        wbValid,
  output logic [31:0] wbAddr
);
  seqStrobe_t strobe;
  logic       inListEmpty;
  logic       lastBeat;
  logic       wbFlag;

  blkseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .beatReady   (beatReady),
    .inListEmpty (inListEmpty),
    .lastBeat    (lastBeat),
    .strobe      (strobe),
    .beatValid   (beatValid),
    .busy        (busy),
    .done        (done)
  );

  blkseq_dp #(.NREG(16), .ADDR_W(32), .WORD_BYTES(4)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .regList     (regList),
    .baseAddr    (baseAddr),
    .addrMode    (addrMode),
    .wbEn        (wbEn),
    .inListEmpty (inListEmpty),
    .lastBeat    (lastBeat),
    .beatIdx     (beatIdx),
    .beatAddr    (beatAddr),
    .wbAddr      (wbAddr),
    .wbFlag      (wbFlag)
  );

  assign wbValid = done & wbFlag;

endmodule

// File: rtl/blkseq_chk.sv
module blkseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        beatReady,
  input logic        beatValid,
  input logic [3:0]  beatIdx,
  input logic [31:0] beatAddr,
  input logic        busy,
  input logic        done,
  input logic        wbValid
);
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !beatReady) |=> (beatValid && $stable(beatIdx) && $stable(beatAddr))); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && beatReady) |=> (!beatValid || (beatAddr == $past(beatAddr) + 32'd4))); // R6

  AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && beatReady) |=> (!beatValid || (beatIdx > $past(beatIdx)))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (done && !beatValid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!beatValid && !done)); // R1

  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !busy); // R11
endmodule

bind blk_addr_seq blkseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .beatReady (beatReady),
  .beatValid (beatValid),
  .beatIdx   (beatIdx),
  .beatAddr  (beatAddr),
  .busy      (busy),
  .done      (done),
  .wbValid   (wbValid)
);

// File: tb/blk_addr_seq_tb.sv
`timescale 1ns/1ps
module blk_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic [1:0]  addrMode = '0;
  logic        wbEn = 1'b0;
  logic        beatReady = 1'b0;
  logic        beatValid, busy, done, wbValid;
  logic [3:0]  beatIdx;
  logic [31:0] beatAddr, wbAddr;

  always #4 clk = ~clk;

  blk_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .regList(regList),
    .baseAddr(baseAddr), .addrMode(addrMode), .wbEn(wbEn),
    .beatReady(beatReady), .beatValid(beatValid), .beatIdx(beatIdx),
    .beatAddr(beatAddr), .busy(busy), .done(done), .wbValid(wbValid),
    .wbAddr(wbAddr)
  );

  typedef struct packed { logic [3:0] idx; logic [31:0] addr; } beat_t;
  typedef struct packed { logic wbv; logic [31:0] wb; } fin_t;
  beat_t beatQ[$];
  fin_t  finQ[$];

  int    checks = 0;
  int    fails = 0;
  int    doneSeen = 0;
  string firstReq = "R2";
  logic  firstBeat = 1'b0;
  logic  readyRandom = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready pattern, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    beatReady = readyRandom ? lfsr[0] : 1'b1;
  end

  // monitor: pops expected items as the design produces them
  logic        holdPend = 1'b0;
  logic [3:0]  holdIdx;
  logic [31:0] holdAddr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (holdPend) begin
        check(beatValid, "R7", "valid dropped while stalled", 32'(beatValid), 32'd1);
        check(beatIdx == holdIdx, "R7", "index moved while stalled", 32'(beatIdx), 32'(holdIdx));
        check(beatAddr == holdAddr, "R7", "address moved while stalled", beatAddr, holdAddr);
      end
      holdPend = beatValid && !beatReady;
      holdIdx  = beatIdx;
      holdAddr = beatAddr;
      if (beatValid && beatReady) begin
        if (beatQ.size() == 0) begin
          check(1'b0, "R6", "unexpected beat", beatAddr, 32'd0);
        end else begin
          beat_t e;
          e = beatQ.pop_front();
          check(beatIdx == e.idx, "R6", "beat index", 32'(beatIdx), 32'(e.idx));
          check(beatAddr == e.addr, firstBeat ? firstReq : "R6", "beat address", beatAddr, e.addr);
          firstBeat = 1'b0;
        end
      end
      if (done) begin
        if (finQ.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 32'd1, 32'd0);
        end else begin
          fin_t f;
          f = finQ.pop_front();
          check(wbValid == f.wbv, "R8", "writeback flag", 32'(wbValid), 32'(f.wbv));
          check(wbAddr == f.wb, "R9", "writeback value", wbAddr, f.wb);
          check(beatQ.size() == 0, "R8", "done before all beats", 32'(beatQ.size()), 32'd0);
        end
        doneSeen++;
      end
    end
  end

  // driver: pushes the expected beats and completion, then launches
  task automatic runXfer(input logic [15:0] lst, input logic [31:0] base,
                         input logic [1:0] mode, input logic wb, input logic poke);
    int n;
    int seen0;
    logic [31:0] a;
    n = $countones(lst);
    case (mode)
      2'd0: begin a = base;                     firstReq = "R2"; end
      2'd1: begin a = base + 32'd4;             firstReq = "R3"; end
      2'd2: begin a = base - 32'(4*n) + 32'd4;  firstReq = "R4"; end
      default: begin a = base - 32'(4*n);       firstReq = "R5"; end
    endcase
    firstBeat = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        beatQ.push_back({4'(i), a});
        a = a + 32'd4;
      end
    end
    finQ.push_back({wb, mode[1] ? base - 32'(4*n) : base + 32'(4*n)});
    seen0 = doneSeen;
    @(posedge clk); #1;
    start = 1'b1; regList = lst; baseAddr = base; addrMode = mode; wbEn = wb;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // relaunch attempt with different parameters for the whole transfer
      regList = ~lst; baseAddr = base ^ 32'h0F00_0000; addrMode = ~mode; wbEn = ~wb;
    end
    if (lst == 16'h0000) begin
      @(negedge clk); #1;
      check(doneSeen == seen0 + 1, "R10", "empty list done latency", 32'(doneSeen - seen0), 32'd1);
    end
    while (doneSeen == seen0) begin
      @(negedge clk); #1;
      if (poke) start = busy;
    end
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk); #1;
    check(!busy && !beatValid, poke ? "R11" : "R8", "idle after done",
          32'({busy, beatValid}), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !beatValid && !done && !wbValid, "R1", "reset state",
          32'({busy, beatValid, done, wbValid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !beatValid, "R1", "idle after reset", 32'({busy, beatValid}), 32'd0);

    readyRandom = 1'b0;
    runXfer(16'h00A5, 32'h0000_1000, 2'd0, 1'b1, 1'b0);
    readyRandom = 1'b1;
    runXfer(16'h8001, 32'h0000_2000, 2'd1, 1'b1, 1'b0);
    runXfer(16'h0F0F, 32'h0000_3000, 2'd2, 1'b0, 1'b0);
    runXfer(16'hFFFF, 32'h0000_0040, 2'd3, 1'b1, 1'b0);
    runXfer(16'h8000, 32'h0000_0100, 2'd2, 1'b1, 1'b0);
    runXfer(16'h0007, 32'h0000_0008, 2'd3, 1'b1, 1'b0);
    runXfer(16'h0000, 32'h5555_5550, 2'd3, 1'b1, 1'b0);
    runXfer(16'h0000, 32'h0000_0ABC, 2'd0, 1'b0, 1'b0);
    runXfer(16'h0110, 32'h0000_0700, 2'd0, 1'b1, 1'b1);
    runXfer(16'h4002, 32'h0000_0900, 2'd3, 1'b1, 1'b1);
    readyRandom = 1'b0;
    runXfer(16'h0000, 32'h0000_1230, 2'd1, 1'b1, 1'b1);

    check(beatQ.size() == 0 && finQ.size() == 0, "R6", "leftover expected items",
          32'(beatQ.size() + finQ.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule